// File: doc/BRIEF.md
# Time-of-Day Counter with Rate Trimming

This block keeps a free-running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. Every clock cycle it advances the time by a programmable period. The period is a fixed-point number: its upper 4 bits are whole nanoseconds and its lower 16 bits are fractions of a nanosecond. A 16-bit fraction accumulator collects the fractional parts and carries into nanoseconds. Nanoseconds carry into seconds.

Three corrections shape the rate and the phase of the clock:
- **Drift trim.** A small fractional amount is added once every programmable number of cycles. This corrects a period that cannot be expressed exactly in 16 fractional bits.
- **Offset slew.** An alternate period is used for a programmed number of cycles. The count runs down to zero and the normal period then resumes. Software polls the remaining count to learn when the slew has finished.
- **Direct load.** A new time value replaces the current one.

Configuration arrives as plain values, each group with its own write strobe. The seconds are presented as a 16-bit upper half and a 32-bit lower half.

Top module: `tod_trim_counter`

## Requirements
- R1: A synchronous active-high reset clears the seconds, the nanoseconds, the fraction accumulator, the normal period, the alternate period, the remaining slew count, the drift amount, the drift interval and the drift cycle counter. After reset the time stays at zero.
- R2: The period is 20 bits: bits [19:16] are whole nanoseconds and bits [15:0] are 1/65536 ns. In each cycle with no load, the time grows by exactly the active period.
- R3: The fraction accumulator carries into nanoseconds. Over n cycles the time grows by exactly n times the period, fractions included.
- R4: Nanoseconds stay below 1,000,000,000. A sum that reaches that value wraps and adds one to the 48-bit seconds. The seconds appear as `todSecHi` (bits 47:32) and `todSecLo` (bits 31:0).
- R5: While the remaining slew count is nonzero, the alternate period replaces the normal period, and the count drops by one each cycle. `adjCountOut` shows the remaining count.
- R6: Once the slew count reaches zero, it stays at zero and the normal period is used again.
- R7: A slew write while a slew is still running restarts the countdown with the new count and the new alternate period, from the cycle after the write.
- R8: With a drift interval D > 0, the 16-bit drift amount (in 1/65536 ns) is added to the step once every D cycles. A load or a drift write restarts this D-cycle count.
- R9: A drift interval of zero disables the drift addition, whatever the drift amount.
- R10: A load strobe makes the output equal the loaded seconds and nanoseconds one cycle after the strobe. The load clears the fraction accumulator, so the following steps start from a zero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periodWe | input | 1 | Write strobe for the normal period |
| periodIn | input | 20 | Normal period, 4.16 fixed-point ns |
| adjWe | input | 1 | Write strobe that starts or restarts an offset slew |
| adjPeriodIn | input | 20 | Alternate period used during the slew |
| adjCountIn | input | 20 | Number of cycles of the slew |
| driftWe | input | 1 | Write strobe for the drift settings |
| driftFracIn | input | 16 | Drift amount in 1/65536 ns |
| driftRateIn | input | 16 | Drift interval in cycles, 0 disables |
| loadStb | input | 1 | Load strobe for a new time value |
| loadSecHi | input | 16 | Seconds bits 47:32 to load |
| loadSecLo | input | 32 | Seconds bits 31:0 to load |
| loadNs | input | 30 | Nanoseconds to load, below 1e9 |
| todSecHi | output | 16 | Live seconds bits 47:32 |
| todSecLo | output | 32 | Live seconds bits 31:0 |
| todNs | output | 30 | Live nanoseconds |
| adjCountOut | output | 20 | Remaining slew cycles, zero when finished |

## Verification
Every result is a register output, and its timing follows from the cycle of the stimulus:
- A load, a slew write or a reset applied before an edge shows at the outputs just after that edge.
- A new period or drift setting first changes the step taken at the following edge, so it is visible two edges after the write.

The driver computes the state the design should hold after each edge and queues it. The monitor compares the outputs once per cycle, just after each rising edge, so every check lands on the first cycle in which a result is due. The model keeps time as one wide count of 1/65536 ns. This exposes a lost fraction carry, a misplaced drift addition or an early or late end of a slew as a mismatch in a specific cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic loadTime;   // replace time with the load value
    logic addDrift;   // add the drift fraction in this step
    logic useAlt;     // step period is the alternate one
  } todStrobes_t;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int RATE_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               periodWe,
  input  logic [PER_W-1:0]   periodIn,
  input  logic               adjWe,
  input  logic [PER_W-1:0]   adjPeriodIn,
  input  logic [CNT_W-1:0]   adjCountIn,
  input  logic               driftWe,
  input  logic [DRIFT_W-1:0] driftFracIn,
  input  logic [RATE_W-1:0]  driftRateIn,
  input  logic               loadStb,
  output todStrobes_t        strobes,
  output logic [PER_W-1:0]   stepPeriod,
  output logic [DRIFT_W-1:0] driftFrac,
  output logic [CNT_W-1:0]   adjCount
);

  logic [PER_W-1:0]  normPeriod;
  logic [PER_W-1:0]  altPeriod;
  logic [RATE_W-1:0] driftRate;
  logic [RATE_W-1:0] driftCnt;
  logic              driftHit;
  logic              slewActive;

  assign slewActive = (adjCount != '0);
  assign driftHit   = (driftRate != '0) && (driftCnt == driftRate - 1'b1);
  assign stepPeriod = slewActive ? altPeriod : normPeriod;

  always_comb begin
    strobes.loadTime = loadStb;
    strobes.addDrift = driftHit;
    strobes.useAlt   = slewActive;
  end

  // period and drift settings
  always_ff @(posedge clk) begin
    if (rst) begin
      normPeriod <= '0;
      driftFrac  <= '0;
      driftRate  <= '0;
    end else begin
      if (periodWe) normPeriod <= periodIn;
      if (driftWe) begin
        driftFrac <= driftFracIn;
        driftRate <= driftRateIn;
      end
    end
  end

  // offset slew countdown, restarted by every write
  always_ff @(posedge clk) begin
    if (rst) begin
      altPeriod <= '0;
      adjCount  <= '0;
    end else if (adjWe) begin
      altPeriod <= adjPeriodIn;
      adjCount  <= adjCountIn;
    end else if (slewActive) begin
      adjCount  <= adjCount - 1'b1;
    end
  end

  // drift interval counter
  always_ff @(posedge clk) begin
    if (rst) begin
      driftCnt <= '0;
    end else if (loadStb || driftWe || driftRate == '0 || driftHit) begin
      driftCnt <= '0;
    end else begin
      driftCnt <= driftCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int PER_W      = 20,
  parameter int FRAC_W     = 16,
  parameter int DRIFT_W    = 16,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic               clk,
  input  logic               rst,
  input  todStrobes_t        strobes,
  input  logic [PER_W-1:0]   stepPeriod,
  input  logic [DRIFT_W-1:0] driftFrac,
  input  logic [SEC_W-1:0]   loadSec,
  input  logic [NS_W-1:0]    loadNs,
  output logic [SEC_W-1:0]   secNow,
  output logic [NS_W-1:0]    nsNow
);

  localparam int SUM_W = FRAC_W + 2;   // fraction plus two carry bits
  localparam int NSX_W = NS_W + 1;
  localparam logic [NSX_W-1:0] NS_LIMIT = NSX_W'(NS_PER_SEC);

  logic [FRAC_W-1:0] fracAcc;
  logic [SUM_W-1:0]  fracSum;
  logic [NSX_W-1:0]  nsSum;
  logic              rollSec;
  logic [NS_W-1:0]   nsNext;

  always_comb begin
    fracSum = SUM_W'(fracAcc) + SUM_W'(stepPeriod[FRAC_W-1:0])
            + (strobes.addDrift ? SUM_W'(driftFrac) : '0);
    nsSum   = NSX_W'(nsNow) + NSX_W'(stepPeriod[PER_W-1:FRAC_W])
            + NSX_W'(fracSum[SUM_W-1:FRAC_W]);
    rollSec = (nsSum >= NS_LIMIT);
    nsNext  = rollSec ? NS_W'(nsSum - NS_LIMIT) : NS_W'(nsSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fracAcc <= '0;
      nsNow   <= '0;
      secNow  <= '0;
    end else if (strobes.loadTime) begin
      fracAcc <= '0;
      nsNow   <= loadNs;
      secNow  <= loadSec;
    end else begin
      fracAcc <= fracSum[FRAC_W-1:0];
      nsNow   <= nsNext;
      if (rollSec) secNow <= secNow + 1'b1;
    end
  end

endmodule

// File: rtl/tod_trim_counter.sv
module tod_trim_counter
  import tod_pkg::*;
#(
  parameter int SEC_HI_W   = 16,
  parameter int SEC_LO_W   = 32,
  parameter int NS_W       = 30,
  parameter int PER_W      = 20,
  parameter int FRAC_W     = 16,
  parameter int CNT_W      = 20,
  parameter int DRIFT_W    = 16,
  parameter int RATE_W     = 16,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                periodWe,
  input  logic [PER_W-1:0]    periodIn,
  input  logic                adjWe,
  input  logic [PER_W-1:0]    adjPeriodIn,
  input  logic [CNT_W-1:0]    adjCountIn,
  input  logic                driftWe,
  input  logic [DRIFT_W-1:0]  driftFracIn,
  input  logic [RATE_W-1:0]   driftRateIn,
  input  logic                loadStb,
  input  logic [SEC_HI_W-1:0] loadSecHi,
  input  logic [SEC_LO_W-1:0] loadSecLo,
  input  logic [NS_W-1:0]     loadNs,
  output logic [SEC_HI_W-1:0] todSecHi,
  output logic [SEC_LO_W-1:0] todSecLo,
  output logic [NS_W-1:0]     todNs,
  output logic [CNT_W-1:0]    adjCountOut
);

  localparam int SEC_W = SEC_HI_W + SEC_LO_W;

  todStrobes_t        strobes;
  logic [PER_W-1:0]   stepPeriod;
  logic [DRIFT_W-1:0] driftFrac;
  logic [SEC_W-1:0]   secNow;

  tod_ctrl #(
    .PER_W(PER_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W), .RATE_W(RATE_W)
  ) ctrl (
    .clk(clk), .rst(rst),
    .periodWe(periodWe), .periodIn(periodIn),
    .adjWe(adjWe), .adjPeriodIn(adjPeriodIn), .adjCountIn(adjCountIn),
    .driftWe(driftWe), .driftFracIn(driftFracIn), .driftRateIn(driftRateIn),
    .loadStb(loadStb),
    .strobes(strobes), .stepPeriod(stepPeriod), .driftFrac(driftFrac),
    .adjCount(adjCountOut)
  );

  tod_datapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .PER_W(PER_W), .FRAC_W(FRAC_W),
    .DRIFT_W(DRIFT_W), .NS_PER_SEC(NS_PER_SEC)
  ) dpath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .stepPeriod(stepPeriod), .driftFrac(driftFrac),
    .loadSec({loadSecHi, loadSecLo}), .loadNs(loadNs),
    .secNow(secNow), .nsNow(todNs)
  );

  assign todSecHi = secNow[SEC_W-1:SEC_LO_W];
  assign todSecLo = secNow[SEC_LO_W-1:0];

endmodule

// File: rtl/tod_trim_counter_chk.sv
module tod_trim_counter_chk #(
  parameter int SEC_HI_W   = 16,
  parameter int SEC_LO_W   = 32,
  parameter int NS_W       = 30,
  parameter int CNT_W      = 20,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic                clk,
  input logic                rst,
  input logic                adjWe,
  input logic [CNT_W-1:0]    adjCountIn,
  input logic                loadStb,
  input logic [SEC_HI_W-1:0] loadSecHi,
  input logic [SEC_LO_W-1:0] loadSecLo,
  input logic [NS_W-1:0]     loadNs,
  input logic [SEC_HI_W-1:0] todSecHi,
  input logic [SEC_LO_W-1:0] todSecLo,
  input logic [NS_W-1:0]     todNs,
  input logic [CNT_W-1:0]    adjCountOut
);

  // reset has no disable: it checks the reset itself
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (todNs == '0 && todSecHi == '0 && todSecLo == '0 && adjCountOut == '0));

  a_r4_ns_below_limit: assert property (@(posedge clk) disable iff (rst)
    todNs < NS_W'(NS_PER_SEC));

  a_r5_count_steps_down: assert property (@(posedge clk) disable iff (rst)
    (!adjWe && adjCountOut != '0) |=> (adjCountOut == $past(adjCountOut) - 1'b1));

  a_r6_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (!adjWe && adjCountOut == '0) |=> (adjCountOut == '0));

  a_r7_restart_takes_new: assert property (@(posedge clk) disable iff (rst)
    adjWe |=> (adjCountOut == $past(adjCountIn)));

  a_r10_load_next_cycle: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (todNs == $past(loadNs) && todSecHi == $past(loadSecHi)
                 && todSecLo == $past(loadSecLo)));

endmodule

bind tod_trim_counter tod_trim_counter_chk #(
  .SEC_HI_W(SEC_HI_W), .SEC_LO_W(SEC_LO_W), .NS_W(NS_W),
  .CNT_W(CNT_W), .NS_PER_SEC(NS_PER_SEC)
) chk (
  .clk(clk), .rst(rst), .adjWe(adjWe), .adjCountIn(adjCountIn),
  .loadStb(loadStb), .loadSecHi(loadSecHi), .loadSecLo(loadSecLo),
  .loadNs(loadNs), .todSecHi(todSecHi), .todSecLo(todSecLo),
  .todNs(todNs), .adjCountOut(adjCountOut)
);

// File: tb/tod_trim_counter_test.sv
`timescale 1ns/1ps
module tod_trim_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        periodWe = 1'b0;
  logic [19:0] periodIn = '0;
  logic        adjWe = 1'b0;
  logic [19:0] adjPeriodIn = '0;
  logic [19:0] adjCountIn = '0;
  logic        driftWe = 1'b0;
  logic [15:0] driftFracIn = '0;
  logic [15:0] driftRateIn = '0;
  logic        loadStb = 1'b0;
  logic [15:0] loadSecHi = '0;
  logic [31:0] loadSecLo = '0;
  logic [29:0] loadNs = '0;
  logic [15:0] todSecHi;
  logic [31:0] todSecLo;
  logic [29:0] todNs;
  logic [19:0] adjCountOut;

  always #2.5 clk = ~clk;

  tod_trim_counter uut (.*);

  typedef struct {
    logic [47:0] sec;
    logic [29:0] ns;
    logic [19:0] cnt;
    string       tag;
  } expItem_t;

  expItem_t q[$];
  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  string phase = "R1";

  localparam logic [127:0] UNITS_PER_SEC = 128'd1000000000 * 128'd65536;

  // reference model: time as one count of 1/65536 ns
  logic [127:0] mTotal = '0;
  logic [19:0]  mPer = '0, mAlt = '0, mCnt = '0;
  logic [15:0]  mDFrac = '0, mDRate = '0, mDCnt = '0;

  task automatic tick();
    logic        hit;
    logic [19:0] per;
    expItem_t    it;
    if (rst) begin
      mTotal = '0; mPer = '0; mAlt = '0; mCnt = '0;
      mDFrac = '0; mDRate = '0; mDCnt = '0;
    end else begin
      hit = (mDRate != 0) && (mDCnt == mDRate - 16'd1);
      per = (mCnt != 0) ? mAlt : mPer;
      if (loadStb)
        mTotal = {80'd0, loadSecHi, loadSecLo} * UNITS_PER_SEC
               + {98'd0, loadNs} * 128'd65536;
      else
        mTotal = mTotal + 128'(per) + (hit ? 128'(mDFrac) : 128'd0);
      if (loadStb || driftWe || mDRate == 0 || hit) mDCnt = 0;
      else mDCnt = mDCnt + 16'd1;
      if (adjWe) begin mAlt = adjPeriodIn; mCnt = adjCountIn; end
      else if (mCnt != 0) mCnt = mCnt - 20'd1;
      if (periodWe) mPer = periodIn;
      if (driftWe) begin mDFrac = driftFracIn; mDRate = driftRateIn; end
    end
    it.sec = 48'(mTotal / UNITS_PER_SEC);
    it.ns  = 30'((mTotal / 128'd65536) % 128'd1000000000);
    it.cnt = mCnt;
    it.tag = phase;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if ({todSecHi, todSecLo} !== e.sec || todNs !== e.ns || adjCountOut !== e.cnt) begin
          errors++;
          $display("FAIL %s: got sec=%0d ns=%0d cnt=%0d expected sec=%0d ns=%0d cnt=%0d",
                   e.tag, {todSecHi, todSecLo}, todNs, adjCountOut, e.sec, e.ns, e.cnt);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset holds everything at zero
    phase = "R1 reset"; rst = 1'b1; run(3);
    rst = 1'b0; phase = "R1 idle after reset"; run(4);

    // R2 R3: 1.5 ns period, fractions carry into ns
    phase = "R2 R3 period 1.5ns";
    periodWe = 1; periodIn = 20'h1_8000; tick(); periodWe = 0;
    run(9);
    phase = "R3 fraction 0x0001";
    periodWe = 1; periodIn = 20'h3_0001; tick(); periodWe = 0;
    run(6);

    // R8: drift every 3 cycles
    phase = "R8 drift every 3";
    periodWe = 1; periodIn = 20'h5_0000;
    driftWe = 1; driftFracIn = 16'h4000; driftRateIn = 16'd3; tick();
    periodWe = 0; driftWe = 0;
    run(12);
    phase = "R8 drift every cycle";
    driftWe = 1; driftFracIn = 16'hC000; driftRateIn = 16'd1; tick(); driftWe = 0;
    run(5);

    // R9: rate zero disables drift
    phase = "R9 drift rate zero";
    driftWe = 1; driftFracIn = 16'hFFFF; driftRateIn = 16'd0; tick(); driftWe = 0;
    run(8);

    // R10 R4: load near a second boundary, then wrap
    phase = "R10 R4 load and wrap";
    loadStb = 1; loadSecHi = 16'h1234; loadSecLo = 32'hFFFF_FFFF; loadNs = 30'd999999990;
    tick(); loadStb = 0;
    run(6);
    // R10: load clears fraction and drift counter
    phase = "R10 load clears fraction";
    periodWe = 1; periodIn = 20'h0_C000;
    driftWe = 1; driftFracIn = 16'h2000; driftRateIn = 16'd4; tick();
    periodWe = 0; driftWe = 0;
    run(3);
    loadStb = 1; loadSecHi = 16'd0; loadSecLo = 32'd77; loadNs = 30'd500; tick(); loadStb = 0;
    run(9);

    // R5 R6: slew with alternate period
    phase = "R5 R6 slew 5 cycles";
    driftWe = 1; driftFracIn = 16'd0; driftRateIn = 16'd0; tick(); driftWe = 0;
    adjWe = 1; adjPeriodIn = 20'hF_0000; adjCountIn = 20'd5; tick(); adjWe = 0;
    run(10);

    // R7: restart while running
    phase = "R7 slew restart";
    adjWe = 1; adjPeriodIn = 20'h8_8000; adjCountIn = 20'd8; tick(); adjWe = 0;
    run(3);
    adjWe = 1; adjPeriodIn = 20'h2_0000; adjCountIn = 20'd4; tick(); adjWe = 0;
    run(8);

    // R1: reset from a busy state
    phase = "R1 reset from running";
    adjWe = 1; adjCountIn = 20'd50; tick(); adjWe = 0;
    run(2);
    rst = 1; tick(); rst = 0;
    run(4);

    run(2);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule